// File: doc/BRIEF.md
# Double-Buffered Event Bank Writer

This block takes a stream of event words on a valid/ready interface and stores them into two external memory banks in turn, so that a host can drain one bank while the other one fills. Each accepted word goes out on a synchronous SRAM-style write port (write enable, bank select, address, data) in the same cycle it is accepted. The memory samples that port on the rising clock edge.

When the bank being written fills up, it is marked full toward the host and writing moves to the other bank. A full bank stays closed until the host pulses that bank's emptied acknowledge. If writing would move into a bank that is still full, the input stream is stalled until the host releases that bank. An end-of-spill pulse closes a partly filled bank early, so the host gets it with its word count. A synchronous reset, applied when the host reinitialises the card, returns the writer to its idle state for the next spill.

The default depth gives each bank room for about one megabyte of 24-bit words.

Top module: `bankw_writer`

## Requirements
- R1: After reset, in_ready is 1, bank_full is 2'b00, both word counts are 0, active_bank is 0 and overflow is 0.
- R2: A word is accepted when in_valid and in_ready are both 1. In that cycle mem_we is 1, mem_bank is the active bank index (0 or 1), mem_addr is that bank's current word count and mem_wdata is in_data. The bank's count, read from bank_words[i*CNT_W +: CNT_W] for bank i, then rises by one. mem_we is 0 in every other cycle.
- R3: The write that brings a bank to DEPTH words sets that bank's bit i of bank_full. On the next cycle active_bank has switched to the other bank.
- R4: A bank's full bit stays set until host_ack bit i is 1 while the bank is full. That acknowledge clears the full bit and the bank's word count on the next cycle.
- R5: A host_ack bit for a bank that is not full is ignored. That bank's full bit and word count are left unchanged.
- R6: in_ready is 0 exactly while the active bank is full, which can only happen when both banks are full. It returns to 1 in the cycle after the host acknowledges the active bank.
- R7: overflow sets when in_valid is 1 while in_ready is 0. It then stays set until reset.
- R8: spill_end closes the active bank when that bank is not full and holds at least one word, counting a word accepted in the same cycle. The bank's full bit sets, its word count is kept for the host, and active_bank switches.
- R9: spill_end while the active bank is empty and no word is accepted has no effect: active_bank and bank_full are unchanged.
- R10: A synchronous reset applied in the middle of filling restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_data | input | DATA_W | Input event word |
| in_ready | output | 1 | Writer can accept a word |
| spill_end | input | 1 | End-of-spill pulse, closes the active bank |
| host_ack | input | 2 | Per-bank emptied acknowledge from host |
| mem_we | output | 1 | Memory write enable |
| mem_bank | output | 1 | Memory bank select |
| mem_addr | output | ADDR_W | Word address within the bank |
| mem_wdata | output | DATA_W | Memory write data |
| bank_full | output | 2 | Per-bank full flag toward host |
| bank_words | output | 2*CNT_W | Per-bank word counts, bank i at bits i*CNT_W upward |
| active_bank | output | 1 | Bank currently being filled |
| overflow | output | 1 | Sticky flag: input pushed during a stall |

## Verification
The bench builds the writer with DEPTH set to 4 and DATA_W set to 24. A four-word bank fills within a few cycles, so bank switching and the stall with both banks full are reached in a short run. So are early closes by end of spill, ignored acknowledges and a reset in the middle of filling. The top address of the bank and the full word count at the count boundary are also driven in the run. The memories are arrays in the bench; their contents are compared with a behavioural model before each bank is acknowledged.

// File: rtl/bankw_pkg.sv
package bankw_pkg;
   localparam int NBANK = 2;
   typedef logic bank_idx_t;
endpackage

// File: rtl/bankw_bank.sv
module bankw_bank #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_i,
   input  logic             close_i,
   input  logic             ack_i,
   output logic [CNT_W-1:0] count_o,
   output logic             full_o,
   output logic             last_o
);
   assign last_o = (count_o == CNT_W'(DEPTH - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         count_o <= '0;
         full_o  <= 1'b0;
      end else if (ack_i && full_o) begin
         count_o <= '0;
         full_o  <= 1'b0;
      end else begin
         if (wr_i)
            count_o <= count_o + 1'b1;
         if ((wr_i && last_o) || close_i)
            full_o <= 1'b1;
      end
   end

   p_ack_empties_r4: assert property (@(posedge clk) disable iff (rst)
      (ack_i && full_o) |=> (!full_o && count_o == '0));
   p_full_holds_r4: assert property (@(posedge clk) disable iff (rst)
      (full_o && !ack_i) |=> full_o);
   p_no_write_full_r6: assert property (@(posedge clk) disable iff (rst)
      full_o |-> !wr_i);
   p_count_cap_r2: assert property (@(posedge clk) disable iff (rst)
      count_o <= CNT_W'(DEPTH));
   p_ack_idle_r5: assert property (@(posedge clk) disable iff (rst)
      (ack_i && !full_o && !wr_i && !close_i) |=> $stable(count_o) && !full_o);
endmodule

// File: rtl/bankw_flow.sv
module bankw_flow (
   input  logic clk,
   input  logic rst,
   input  logic switch_i,
   input  logic forced_i,
   output logic act_o,
   output logic ovf_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         act_o <= 1'b0;
         ovf_o <= 1'b0;
      end else begin
         if (switch_i)
            act_o <= ~act_o;
         if (forced_i)
            ovf_o <= 1'b1;
      end
   end

   p_switch_flips_r3: assert property (@(posedge clk) disable iff (rst)
      switch_i |=> (act_o != $past(act_o)));
   p_hold_no_switch_r9: assert property (@(posedge clk) disable iff (rst)
      !switch_i |=> $stable(act_o));
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      ovf_o |=> ovf_o);
endmodule

// File: rtl/bankw_writer.sv
module bankw_writer
   import bankw_pkg::*;
#(
   parameter int DEPTH  = 349525,
   parameter int DATA_W = 24,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [DATA_W-1:0]    in_data,
   output logic                 in_ready,
   input  logic                 spill_end,
   input  logic [1:0]           host_ack,
   output logic                 mem_we,
   output logic                 mem_bank,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [DATA_W-1:0]    mem_wdata,
   output logic [1:0]           bank_full,
   output logic [2*CNT_W-1:0]   bank_words,
   output logic                 active_bank,
   output logic                 overflow
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("bankw_writer: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("bankw_writer: DATA_W must be at least 1");
   end

   bank_idx_t        act;
   logic             fire;
   logic             switch_now;
   logic [NBANK-1:0] wr_v, close_v, last_v, full_v;
   logic [CNT_W-1:0] cnt [NBANK];

   assign in_ready = !full_v[act];
   assign fire     = in_valid && in_ready;

   for (genvar i = 0; i < NBANK; i++) begin : g_bank
      assign wr_v[i]    = fire && (act == bank_idx_t'(i));
      assign close_v[i] = spill_end && (act == bank_idx_t'(i)) && !full_v[i]
                          && ((cnt[i] != '0) || wr_v[i]);

      bankw_bank #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_bank (
         .clk     (clk),
         .rst     (rst),
         .wr_i    (wr_v[i]),
         .close_i (close_v[i]),
         .ack_i   (host_ack[i]),
         .count_o (cnt[i]),
         .full_o  (full_v[i]),
         .last_o  (last_v[i])
      );

      assign bank_words[i*CNT_W +: CNT_W] = cnt[i];
   end

   assign switch_now = |((wr_v & last_v) | close_v);

   bankw_flow u_flow (
      .clk      (clk),
      .rst      (rst),
      .switch_i (switch_now),
      .forced_i (in_valid && !in_ready),
      .act_o    (act),
      .ovf_o    (overflow)
   );

   assign mem_we      = fire;
   assign mem_bank    = act;
   assign mem_addr    = cnt[act][ADDR_W-1:0];
   assign mem_wdata   = in_data;
   assign bank_full   = full_v;
   assign active_bank = act;

   p_stall_both_full_r6: assert property (@(posedge clk) disable iff (rst)
      !in_ready |-> (bank_full == 2'b11));
   p_we_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (in_valid && in_ready));
   p_spill_closes_r8: assert property (@(posedge clk) disable iff (rst)
      (spill_end && !bank_full[active_bank] && (fire || cnt[active_bank] != '0))
      |=> bank_full[$past(active_bank)]);
   p_spill_empty_r9: assert property (@(posedge clk) disable iff (rst)
      (spill_end && !fire && cnt[active_bank] == '0 && !bank_full[active_bank]
       && host_ack == 2'b00) |=> $stable(active_bank) && $stable(bank_full));
endmodule

// File: tb/bankw_writer_test.sv
module bankw_writer_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 4;
   localparam int DATA_W = 24;
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic clk = 0;
   logic rst = 1;
   logic in_valid = 0;
   logic [DATA_W-1:0] in_data = '0;
   logic in_ready;
   logic spill_end = 0;
   logic [1:0] host_ack = 2'b00;
   logic mem_we, mem_bank;
   logic [AW-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic [1:0] bank_full;
   logic [2*CW-1:0] bank_words;
   logic active_bank, overflow;

   bankw_writer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .spill_end(spill_end), .host_ack(host_ack),
      .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .bank_full(bank_full), .bank_words(bank_words),
      .active_bank(active_bank), .overflow(overflow)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [DATA_W-1:0] bmem [2][DEPTH];
   always @(posedge clk) if (mem_we) bmem[mem_bank][mem_addr] <= mem_wdata;

   int checks = 0, fails = 0;
   bit done = 0;
   int m_cnt [2];
   bit m_full [2];
   int m_act;
   bit m_ovf;
   logic [DATA_W-1:0] exp_mem [2][DEPTH];
   int seq = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int words(input int b);
      return int'(bank_words[b*CW +: CW]);
   endfunction

   task automatic step(input bit v, input bit se, input bit [1:0] ak, input bit r);
      bit pr, fire;
      bit of [2];
      int a;
      logic [DATA_W-1:0] d;
      d = DATA_W'(24'h5A0000 + seq);
      seq++;
      in_valid = v; in_data = d; spill_end = se; host_ack = ak; rst = r;
      #1;
      if (!r) begin
         pr = !m_full[m_act];
         chk(in_ready === pr, "R6", "in_ready", in_ready, pr);
         fire = v && pr;
         chk(mem_we === fire, "R2", "mem_we", mem_we, fire);
         if (fire) begin
            chk(mem_bank === 1'(m_act), "R2", "mem_bank", mem_bank, m_act);
            chk(int'(mem_addr) == m_cnt[m_act], "R2", "mem_addr", mem_addr, m_cnt[m_act]);
            chk(mem_wdata === d, "R2", "mem_wdata", mem_wdata, d);
         end
      end
      @(posedge clk);
      if (r) begin
         m_full[0] = 0; m_full[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
         m_act = 0; m_ovf = 0;
      end else begin
         a = m_act; of[0] = m_full[0]; of[1] = m_full[1];
         pr = !m_full[a]; fire = v && pr;
         if (v && !pr) m_ovf = 1;
         if (fire) begin exp_mem[a][m_cnt[a]] = d; m_cnt[a]++; end
         if (!of[a] && ((fire && m_cnt[a] == DEPTH) || (se && m_cnt[a] > 0))) begin
            m_full[a] = 1; m_act = 1 - a;
         end
         for (int b = 0; b < 2; b++)
            if (ak[b] && of[b]) begin m_full[b] = 0; m_cnt[b] = 0; end
      end
      @(negedge clk);
      in_valid = 0; spill_end = 0; host_ack = 2'b00; rst = 0;
      for (int b = 0; b < 2; b++) begin
         chk(bank_full[b] === m_full[b], "R4", "bank_full bit", bank_full[b], m_full[b]);
         chk(words(b) == m_cnt[b], "R2", "bank_words", words(b), m_cnt[b]);
      end
      chk(active_bank === 1'(m_act), "R3", "active_bank", active_bank, m_act);
      chk(overflow === m_ovf, "R7", "overflow", overflow, m_ovf);
   endtask

   task automatic drain(input int b);
      for (int i = 0; i < m_cnt[b]; i++)
         chk(bmem[b][i] === exp_mem[b][i], "R2", "stored word", bmem[b][i], exp_mem[b][i]);
   endtask

   task automatic check_idle(input string req);
      chk(in_ready === 1'b1, req, "in_ready idle", in_ready, 1);
      chk(bank_full === 2'b00, req, "bank_full idle", bank_full, 0);
      chk(bank_words === '0, req, "bank_words idle", bank_words, 0);
      chk(active_bank === 1'b0, req, "active_bank idle", active_bank, 0);
      chk(overflow === 1'b0, req, "overflow idle", overflow, 0);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      @(negedge clk);
      step(0, 0, 2'b00, 1);
      step(0, 0, 2'b00, 1);
      check_idle("R1");

      // R3: fill bank 0 with a gap in the stream
      step(1, 0, 2'b00, 0);
      step(0, 0, 2'b00, 0);
      step(1, 0, 2'b00, 0);
      step(1, 0, 2'b00, 0);
      step(1, 0, 2'b00, 0);
      chk(bank_full == 2'b01, "R3", "bank0 full after DEPTH words", bank_full, 1);
      chk(active_bank == 1'b1, "R3", "switched to bank1", active_bank, 1);

      // R5: acknowledge of a bank that is not full
      step(1, 0, 2'b00, 0);
      step(0, 0, 2'b10, 0);
      chk(words(1) == 1, "R5", "bank1 count after stray ack", words(1), 1);
      chk(bank_full == 2'b01, "R5", "bank_full after stray ack", bank_full, 1);

      // R6/R7: fill bank1, stall, push while stalled
      step(1, 0, 2'b00, 0);
      step(1, 0, 2'b00, 0);
      step(1, 0, 2'b00, 0);
      chk(bank_full == 2'b11, "R6", "both banks full", bank_full, 3);
      chk(in_ready == 1'b0, "R6", "stalled", in_ready, 0);
      step(1, 0, 2'b00, 0);
      chk(overflow == 1'b1, "R7", "overflow on forced input", overflow, 1);
      step(0, 0, 2'b00, 0);
      step(0, 0, 2'b00, 0);
      chk(bank_full == 2'b11, "R4", "full held without ack", bank_full, 3);

      // R4: host drains bank 0 and acknowledges
      drain(0);
      step(0, 0, 2'b01, 0);
      chk(bank_full == 2'b10 && words(0) == 0, "R4", "bank0 released", bank_full, 2);
      chk(in_ready == 1'b1, "R6", "ready after ack", in_ready, 1);

      // R8: spill end with a word in the same cycle
      step(1, 0, 2'b00, 0);
      step(1, 1, 2'b00, 0);
      chk(words(0) == 2, "R8", "closed bank count", words(0), 2);
      chk(bank_full[0] == 1'b1, "R8", "closed bank full", bank_full[0], 1);
      chk(active_bank == 1'b1, "R8", "switched after close", active_bank, 1);

      // R9: spill end on an empty active bank
      drain(1);
      step(0, 0, 2'b10, 0);
      step(0, 1, 2'b00, 0);
      chk(active_bank == 1'b1, "R9", "active unchanged", active_bank, 1);
      chk(bank_full == 2'b01, "R9", "bank_full unchanged", bank_full, 1);

      // R8: spill end alone on a partly filled bank
      step(1, 0, 2'b00, 0);
      step(0, 1, 2'b00, 0);
      chk(bank_full == 2'b11 && words(1) == 1, "R8", "close without write", words(1), 1);
      drain(0);
      drain(1);
      step(0, 0, 2'b11, 0);
      step(1, 0, 2'b00, 0);
      step(1, 0, 2'b00, 0);

      // R10: reset in the middle of filling
      step(0, 0, 2'b00, 1);
      check_idle("R10");
      step(1, 0, 2'b00, 0);
      drain(0);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         summary();
         $finish;
      end
   end
endmodule